// File: doc/BRIEF.md
# Bus-Mapped Asynchronous Serial Controller

This block is a byte-wide serial port that sits on a simple 8-bit processor bus. The processor selects it with a chip-select and picks one of four register slots with a two-bit select. A read/write strobe then turns those four slots into eight distinct operations. Writing the data slot queues a byte for transmission, and reading it returns the last received byte. Writing the status slot performs a programmed reset, and reading it returns the flags. The command and control slots are plain read/write registers.

The transmitter sends 8N1 frames on `txd` through a holding register and a shift register. A byte may only start while `cts_n` is low, and a byte that has started always finishes. The receiver oversamples `rxd` and keeps one received byte. It reports overrun and framing errors. It can raise an active-low interrupt on every received character, and that interrupt is cleared by reading the status register.

Bit timing comes from a 16x oversample tick. That tick is derived from `ref_en`, a one-cycle strobe at the 1.8432 MHz reference rate. The rate divisor is picked by the low four bits of the control register.

Top module: `serial_bus_port`

## Requirements
- R1: A bus access is a cycle with `cs`=1. `rd_wr_n`=1 reads and 0 writes. With `rsel`=00 a write loads the transmit holding register and a read returns the receive byte. With `rsel`=10 the command register is accessed and with 11 the control register; both read back all 8 bits. `term_rdy_n` is the inverse of command bit 0. `rdata` is 0 when no read is in progress.
- R2: The status byte has bit 7 = interrupt pending, bit 4 = transmit holding empty, bit 3 = receive full, bit 2 = overrun and bit 1 = framing error. Bits 6, 5 and 0 read 0. After hardware reset, status reads 0x10, command and control read 0x00, and `txd`, `irq_n` and `term_rdy_n` are 1.
- R3: Status bit 4 drops to 0 on the cycle after a data write. It returns to 1 only when the shift path has taken the byte. It stays 0 while a second byte waits behind a frame that is still being sent.
- R4: Each transmitted frame is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Every bit lasts 16 oversample ticks.
- R5: Control bits [3:0] set the oversample divisor in reference strobes. 1111 gives 6 (19200 baud), 1110 gives 12 (9600), 1100 gives 24 (4800), 1010 gives 48 (2400) and 1000 gives 96 (1200). Every other code gives 48.
- R6: A queued byte starts only while `cts_n` is 0. A frame that has started is sent in full even if `cts_n` rises during it.
- R7: The receiver synchronises `rxd`. It confirms a start bit 8 ticks after the falling edge and samples each later bit 16 ticks apart. It then stores the byte and sets the receive-full flag.
- R8: If a character completes while the receive byte is still unread, the overrun flag is set and the stored byte is kept.
- R9: A low stop bit sets the framing flag together with its byte. The receiver then waits for the line to return high before it looks for a new start bit.
- R10: With command bit 1 = 1, each completed character sets status bit 7 and drives `irq_n` low. With command bit 1 = 0, received characters leave `irq_n` high and bit 7 at 0.
- R11: Reading status clears the interrupt and releases `irq_n`. Reading the receive byte clears the receive-full, overrun and framing flags.
- R12: A write to `rsel`=01 clears, whatever the data value, the interrupt, receive-full, overrun and framing flags and command bits [4:0]. It leaves command bits [7:5] and the whole control register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, one access per cycle while high |
| rsel | input | 2 | Register slot select |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor |
| irq_n | output | 1 | Active-low interrupt request |
| term_rdy_n | output | 1 | Active-low terminal-ready line from command bit 0 |
| ref_en | input | 1 | Reference-rate strobe (1.8432 MHz pulses) |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Active-low clear-to-send |

## Verification
Transmit is exercised in three ways. A pair of back-to-back bytes at 19200 separates holding-register emptiness from shifter activity. Bytes queued while clear-to-send is withheld or dropped mid-frame separate start gating from in-flight abortion. Single bytes at 2400 and under an unlisted rate code confirm the divisor table and its fallback. Receive is exercised with clean characters, with two characters sent without a read in between, and with a character carrying a low stop bit followed by a clean one. Between them these patterns tell apart the overrun, framing and recovery paths from ordinary reception. Interrupt-enabled and interrupt-disabled receptions, status and data reads, and a programmed reset over a dirty flag state show which flags each bus operation clears and which registers it preserves.

// File: rtl/serial_bus_pkg.sv
package serial_bus_pkg;

   localparam int BUS_W = 8;
   localparam int DIV_W = 12;

   // register slot decode (rsel)
   typedef enum logic [1:0] {
      SEL_DATA = 2'b00,
      SEL_STAT = 2'b01,
      SEL_CMD  = 2'b10,
      SEL_CTRL = 2'b11
   } reg_sel_e;

   // status bit positions
   localparam int STAT_IRQ  = 7;
   localparam int STAT_TDRE = 4;
   localparam int STAT_RDRF = 3;
   localparam int STAT_OVRN = 2;
   localparam int STAT_FERR = 1;

   // command bit positions
   localparam int CMD_RDY       = 0;
   localparam int CMD_RXIE      = 1;
   localparam int CMD_CLR_BITS  = 5;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_BREAK
   } rx_state_e;

   // oversample divisor, in reference strobes, for a 16x tick
   function automatic logic [DIV_W-1:0] rate_divisor(input logic [3:0] code);
      case (code)
         4'b1111: rate_divisor = 12'd6;
         4'b1110: rate_divisor = 12'd12;
         4'b1100: rate_divisor = 12'd24;
         4'b1010: rate_divisor = 12'd48;
         4'b1000: rate_divisor = 12'd96;
         default: rate_divisor = 12'd48;
      endcase
   endfunction

endpackage

// File: rtl/sbp_baud_gen.sv
module sbp_baud_gen #(
   parameter int DIV_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  logic [DIV_W-1:0] divisor,
   output logic             os_tick
);

   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt >= divisor - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         os_tick <= 1'b0;
      end else begin
         os_tick <= ref_en && wrap;
         if (ref_en) cnt <= wrap ? '0 : cnt + 1'b1;
      end
   end

   // R5: the smallest divisor is 6, so ticks never come back to back
   p_tick_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      os_tick |=> !os_tick);

endmodule

// File: rtl/sbp_tx.sv
module sbp_tx #(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              hold_vld,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              cts_n,
   output logic              take,
   output logic              txd
);

   localparam int FRAME = DATA_W + 2;
   localparam int IDX_W = $clog2(FRAME);
   localparam int OS_W  = $clog2(OVERSAMPLE);
   localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME - 1);
   localparam logic [OS_W-1:0]  LAST_OS  = OS_W'(OVERSAMPLE - 1);

   logic             busy;
   logic [FRAME-1:0] shreg;
   logic [IDX_W-1:0] bit_idx;
   logic [OS_W-1:0]  os_cnt;

   // a new frame may only begin while the far end grants clear-to-send
   assign take = !busy && hold_vld && !cts_n;
   assign txd  = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         shreg   <= '1;
         bit_idx <= '0;
         os_cnt  <= '0;
      end else if (take) begin
         busy    <= 1'b1;
         shreg   <= {1'b1, hold_data, 1'b0};
         bit_idx <= '0;
         os_cnt  <= '0;
      end else if (busy && os_tick) begin
         if (os_cnt == LAST_OS) begin
            os_cnt <= '0;
            if (bit_idx == LAST_BIT) begin
               busy <= 1'b0;
            end else begin
               bit_idx <= bit_idx + 1'b1;
               shreg   <= {1'b1, shreg[FRAME-1:1]};
            end
         end else begin
            os_cnt <= os_cnt + 1'b1;
         end
      end
   end

   // R6: a frame only ends after its stop bit, regardless of cts_n
   p_frame_not_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(bit_idx) == LAST_BIT && $past(os_tick)));

   // R6: frames start only under clear-to-send
   p_start_needs_cts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(cts_n));

   // R4: the last bit of a frame is a high stop bit
   p_stop_bit_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bit_idx == LAST_BIT) |-> txd);

endmodule

// File: rtl/sbp_rx.sv
module sbp_rx
   import serial_bus_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rxd,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              stop_ok
);

   localparam int OS_W = $clog2(OVERSAMPLE);
   localparam int BI_W = $clog2(DATA_W);
   localparam logic [OS_W-1:0] HALF_OS = OS_W'(OVERSAMPLE / 2 - 1);
   localparam logic [OS_W-1:0] LAST_OS = OS_W'(OVERSAMPLE - 1);
   localparam logic [BI_W-1:0] LAST_BI = BI_W'(DATA_W - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   rx_state_e              state;
   logic [OS_W-1:0]        os_cnt;
   logic [BI_W-1:0]        bit_idx;
   logic [DATA_W-1:0]      shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
   end

   assign rx_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         os_cnt  <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         done    <= 1'b0;
         data    <= '0;
         stop_ok <= 1'b1;
      end else begin
         done <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (!rx_s) begin
                  state  <= RX_START;
                  os_cnt <= '0;
               end
            end
            RX_START: begin
               if (os_tick) begin
                  if (os_cnt == HALF_OS) begin
                     os_cnt  <= '0;
                     bit_idx <= '0;
                     state   <= rx_s ? RX_IDLE : RX_DATA;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (os_tick) begin
                  if (os_cnt == LAST_OS) begin
                     os_cnt <= '0;
                     shreg  <= {rx_s, shreg[DATA_W-1:1]};
                     if (bit_idx == LAST_BI) state <= RX_STOP;
                     else                    bit_idx <= bit_idx + 1'b1;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (os_tick) begin
                  if (os_cnt == LAST_OS) begin
                     os_cnt  <= '0;
                     done    <= 1'b1;
                     data    <= shreg;
                     stop_ok <= rx_s;
                     state   <= rx_s ? RX_IDLE : RX_BREAK;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
            end
            RX_BREAK: begin
               if (rx_s) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R7: a character completes only on an oversample tick
   p_done_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(os_tick));

   // R9: after a low stop bit the receiver holds off until the line is high
   p_break_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_BREAK && !rx_s) |=> state == RX_BREAK);

endmodule

// File: rtl/serial_bus_port.sv
module serial_bus_port
   import serial_bus_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs,
   input  logic [1:0]       rsel,
   input  logic             rd_wr_n,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             irq_n,
   output logic             term_rdy_n,
   input  logic             ref_en,
   output logic             txd,
   input  logic             rxd,
   input  logic             cts_n
);

   initial begin
      assert (OVERSAMPLE >= 4 && (OVERSAMPLE & (OVERSAMPLE - 1)) == 0)
         else $error("OVERSAMPLE must be a power of two of at least 4");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
   end

   reg_sel_e         sel;
   logic             rd, wr;
   logic             rd_data, rd_stat, wr_data, wr_stat, wr_cmd, wr_ctrl;

   logic [BUS_W-1:0] cmd_q, ctrl_q, hold_q, rx_buf;
   logic             hold_vld, rx_full, ovrn, ferr, irq_q;
   logic             full_eff;
   logic [BUS_W-1:0] status_v;
   logic [DIV_W-1:0] divisor;

   logic             os_tick, tx_take;
   logic             rx_done, rx_stop_ok;
   logic [BUS_W-1:0] rx_byte;

   assign sel     = reg_sel_e'(rsel);
   assign rd      = cs && rd_wr_n;
   assign wr      = cs && !rd_wr_n;
   assign rd_data = rd && (sel == SEL_DATA);
   assign rd_stat = rd && (sel == SEL_STAT);
   assign wr_data = wr && (sel == SEL_DATA);
   assign wr_stat = wr && (sel == SEL_STAT);
   assign wr_cmd  = wr && (sel == SEL_CMD);
   assign wr_ctrl = wr && (sel == SEL_CTRL);

   assign divisor = rate_divisor(ctrl_q[3:0]);

   sbp_baud_gen #(.DIV_W(DIV_W)) i_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_en  (ref_en),
      .divisor (divisor),
      .os_tick (os_tick)
   );

   sbp_tx #(.DATA_W(BUS_W), .OVERSAMPLE(OVERSAMPLE)) i_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .os_tick   (os_tick),
      .hold_vld  (hold_vld),
      .hold_data (hold_q),
      .cts_n     (cts_n),
      .take      (tx_take),
      .txd       (txd)
   );

   sbp_rx #(.DATA_W(BUS_W), .OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) i_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .os_tick (os_tick),
      .rxd     (rxd),
      .done    (rx_done),
      .data    (rx_byte),
      .stop_ok (rx_stop_ok)
   );

   // the buffer counts as free if this cycle's read or reset empties it
   assign full_eff = rx_full && !rd_data && !wr_stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         ctrl_q   <= '0;
         hold_q   <= '0;
         hold_vld <= 1'b0;
         rx_buf   <= '0;
         rx_full  <= 1'b0;
         ovrn     <= 1'b0;
         ferr     <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         if (wr_data) begin
            hold_q   <= wdata;
            hold_vld <= 1'b1;
         end else if (tx_take) begin
            hold_vld <= 1'b0;
         end

         if (wr_ctrl) ctrl_q <= wdata;

         if (wr_cmd)       cmd_q <= wdata;
         else if (wr_stat) cmd_q[CMD_CLR_BITS-1:0] <= '0;

         if (rd_stat || wr_stat) irq_q <= 1'b0;

         if (rd_data || wr_stat) begin
            rx_full <= 1'b0;
            ovrn    <= 1'b0;
            ferr    <= 1'b0;
         end

         if (rx_done) begin
            if (full_eff) begin
               ovrn <= 1'b1;
            end else begin
               rx_buf  <= rx_byte;
               rx_full <= 1'b1;
               ferr    <= !rx_stop_ok;
            end
            if (cmd_q[CMD_RXIE]) irq_q <= 1'b1;
         end
      end
   end

   always_comb begin
      status_v            = '0;
      status_v[STAT_IRQ]  = irq_q;
      status_v[STAT_TDRE] = !hold_vld;
      status_v[STAT_RDRF] = rx_full;
      status_v[STAT_OVRN] = ovrn;
      status_v[STAT_FERR] = ferr;
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (sel)
            SEL_DATA: rdata = rx_buf;
            SEL_STAT: rdata = status_v;
            SEL_CMD:  rdata = cmd_q;
            SEL_CTRL: rdata = ctrl_q;
            default:  rdata = '0;
         endcase
      end
   end

   assign irq_n      = !irq_q;
   assign term_rdy_n = !cmd_q[CMD_RDY];

   // R3: a data write always leaves the holding register marked busy
   p_tdre_drops_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> !status_v[STAT_TDRE]);

   // R8: an overrun keeps the unread byte and raises the flag
   p_overrun_keeps_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && full_eff) |=> ($stable(rx_buf) && ovrn));

   // R10: an interrupt only rises for a received character with the enable set
   p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(cmd_q[CMD_RXIE] && rx_done));

   // R11: a status read with no new character releases the interrupt line
   p_status_read_releases_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !rx_done) |=> irq_n);

endmodule

// File: tb/test_serial_bus_port.sv
module test_serial_bus_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0;
   logic [1:0] rsel = 2'b00;
   logic       rd_wr_n = 1'b1;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq_n;
   logic       term_rdy_n;
   logic       ref_en = 1'b1;
   logic       txd;
   logic       rxd = 1'b1;
   logic       cts_n = 1'b0;

   int n_checks = 0;
   int n_err    = 0;

   localparam logic [1:0] A_DATA = 2'b00;
   localparam logic [1:0] A_STAT = 2'b01;
   localparam logic [1:0] A_CMD  = 2'b10;
   localparam logic [1:0] A_CTRL = 2'b11;

   localparam int P19200 = 96;
   localparam int P9600  = 192;
   localparam int P2400  = 768;

   always #5 clk = ~clk;

   serial_bus_port i_serial_bus_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs),
      .rsel       (rsel),
      .rd_wr_n    (rd_wr_n),
      .wdata      (wdata),
      .rdata      (rdata),
      .irq_n      (irq_n),
      .term_rdy_n (term_rdy_n),
      .ref_en     (ref_en),
      .txd        (txd),
      .rxd        (rxd),
      .cts_n      (cts_n)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; rd_wr_n = 1'b0; rsel = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; rd_wr_n = 1'b1;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; rd_wr_n = 1'b1; rsel = a;
      #1 d = rdata;
      @(negedge clk);
      cs = 1'b0;
   endtask

   // capture one frame from txd, sampling at the middle of each bit
   task automatic recv(input int per, output logic [7:0] b, output logic stopv,
                       output logic ok);
      int t = 0;
      ok = 1'b0; b = 8'h00; stopv = 1'b0;
      while (t < 20000 && txd !== 1'b0) begin
         @(negedge clk);
         t++;
      end
      if (txd !== 1'b0) return;
      repeat (per / 2) @(negedge clk);
      if (txd !== 1'b0) return;
      for (int i = 0; i < 8; i++) begin
         repeat (per) @(negedge clk);
         b[i] = txd;
      end
      repeat (per) @(negedge clk);
      stopv = txd;
      ok = 1'b1;
   endtask

   task automatic send(input int per, input logic [7:0] b, input logic stopv);
      @(negedge clk);
      rxd = 1'b0;
      repeat (per) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (per) @(negedge clk);
      end
      rxd = stopv;
      repeat (per) @(negedge clk);
      rxd = 1'b1;
      repeat (per) @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [7:0] v;
      bus_read(A_STAT, v); chk("R2", "status after reset", v, 8'h10);
      bus_read(A_CMD, v);  chk("R2", "command after reset", v, 8'h00);
      bus_read(A_CTRL, v); chk("R2", "control after reset", v, 8'h00);
      chk("R2", "txd idle", txd, 1'b1);
      chk("R2", "irq_n idle", irq_n, 1'b1);
      chk("R2", "term_rdy_n idle", term_rdy_n, 1'b1);
      chk("R1", "rdata with no read", rdata, 8'h00);
   endtask

   task automatic t_register_access();
      logic [7:0] v;
      bus_write(A_CTRL, 8'h9F);
      bus_write(A_CMD, 8'h0B);
      bus_read(A_CTRL, v); chk("R1", "control readback", v, 8'h9F);
      bus_read(A_CMD, v);  chk("R1", "command readback", v, 8'h0B);
      chk("R1", "term_rdy_n from command bit 0", term_rdy_n, 1'b0);
   endtask

   task automatic t_tx_back_to_back();
      logic [7:0] v;
      logic [7:0] b1, b2;
      logic s1, s2, ok1, ok2;
      fork
         begin
            recv(P19200, b1, s1, ok1);
            recv(P19200, b2, s2, ok2);
         end
         begin
            bus_write(A_DATA, 8'hA5);
            repeat (3) @(negedge clk);
            bus_write(A_DATA, 8'h3C);
            bus_read(A_STAT, v);
            chk("R3", "holding full behind busy shifter", v[4], 1'b0);
            repeat (1400) @(negedge clk);
            bus_read(A_STAT, v);
            chk("R3", "holding empty after second byte taken", v[4], 1'b1);
         end
      join
      chk("R4", "first frame seen", ok1, 1'b1);
      chk("R4", "first byte LSB first", b1, 8'hA5);
      chk("R4", "first stop bit", s1, 1'b1);
      chk("R5", "second byte at 19200", b2, 8'h3C);
      chk("R4", "second stop bit", s2, 1'b1);
   endtask

   task automatic t_cts_gating();
      logic [7:0] v, b;
      logic s, ok;
      cts_n = 1'b1;
      bus_write(A_DATA, 8'h0F);
      bus_read(A_STAT, v);
      chk("R3", "empty flag low while held by cts", v[4], 1'b0);
      repeat (300) @(negedge clk);
      chk("R6", "no start without cts", txd, 1'b1);
      fork
         recv(P19200, b, s, ok);
         begin
            cts_n = 1'b0;
            repeat (400) @(negedge clk);
            cts_n = 1'b1;
         end
      join
      chk("R6", "frame completes after cts drop", ok, 1'b1);
      chk("R6", "byte intact after cts drop", b, 8'h0F);
      chk("R6", "stop bit after cts drop", s, 1'b1);
      bus_read(A_STAT, v);
      chk("R3", "empty after frame taken", v[4], 1'b1);
      bus_write(A_DATA, 8'h81);
      repeat (1200) @(negedge clk);
      chk("R6", "second byte held while cts high", txd, 1'b1);
      bus_read(A_STAT, v);
      chk("R3", "empty flag still low while held", v[4], 1'b0);
      fork
         recv(P19200, b, s, ok);
         cts_n = 1'b0;
      join
      chk("R6", "held byte sent after cts returns", b, 8'h81);
   endtask

   task automatic t_rate_select();
      logic [7:0] b;
      logic s, ok;
      bus_write(A_CTRL, 8'h9A);
      fork
         recv(P2400, b, s, ok);
         bus_write(A_DATA, 8'hC3);
      join
      chk("R5", "byte at 2400", b, 8'hC3);
      chk("R5", "stop at 2400", s, 1'b1);
      bus_write(A_CTRL, 8'h90);
      fork
         recv(P2400, b, s, ok);
         bus_write(A_DATA, 8'h96);
      join
      chk("R5", "unlisted code falls back to 2400", b, 8'h96);
   endtask

   task automatic t_rx_irq();
      logic [7:0] v;
      bus_write(A_CTRL, 8'h9E);
      bus_write(A_CMD, 8'h0B);
      send(P9600, 8'h5A, 1'b1);
      chk("R10", "irq_n low after character", irq_n, 1'b0);
      bus_read(A_STAT, v);
      chk("R7", "status with byte and irq", v, 8'h98);
      chk("R11", "irq_n released by status read", irq_n, 1'b1);
      bus_read(A_STAT, v);
      chk("R11", "status bit 7 cleared", v, 8'h18);
      bus_read(A_DATA, v);
      chk("R7", "received byte at 9600", v, 8'h5A);
      bus_read(A_STAT, v);
      chk("R11", "full cleared by data read", v, 8'h10);
   endtask

   task automatic t_overrun();
      logic [7:0] v;
      send(P9600, 8'h11, 1'b1);
      send(P9600, 8'h22, 1'b1);
      bus_read(A_STAT, v);
      chk("R8", "overrun status", v, 8'h9C);
      bus_read(A_DATA, v);
      chk("R8", "first byte kept", v, 8'h11);
      bus_read(A_STAT, v);
      chk("R11", "overrun cleared by data read", v, 8'h10);
   endtask

   task automatic t_framing();
      logic [7:0] v;
      send(P9600, 8'h33, 1'b0);
      bus_read(A_STAT, v);
      chk("R9", "framing status", v, 8'h9A);
      bus_read(A_DATA, v);
      chk("R9", "byte with bad stop", v, 8'h33);
      send(P9600, 8'h44, 1'b1);
      bus_read(A_STAT, v);
      chk("R9", "clean character after framing error", v, 8'h98);
      bus_read(A_DATA, v);
      chk("R9", "byte after recovery", v, 8'h44);
   endtask

   task automatic t_irq_disabled();
      logic [7:0] v;
      bus_write(A_CMD, 8'h09);
      send(P9600, 8'h66, 1'b1);
      chk("R10", "irq_n stays high when disabled", irq_n, 1'b1);
      bus_read(A_STAT, v);
      chk("R10", "no irq bit when disabled", v, 8'h18);
      bus_read(A_DATA, v);
      chk("R7", "byte with irq disabled", v, 8'h66);
   endtask

   task automatic t_prog_reset();
      logic [7:0] v;
      bus_write(A_CMD, 8'hEB);
      send(P9600, 8'h77, 1'b1);
      send(P9600, 8'h78, 1'b1);
      chk("R12", "irq pending before reset", irq_n, 1'b0);
      bus_write(A_STAT, 8'hFF);
      chk("R12", "irq_n released by reset", irq_n, 1'b1);
      bus_read(A_STAT, v);
      chk("R12", "flags cleared by reset", v, 8'h10);
      bus_read(A_CMD, v);
      chk("R12", "command low bits cleared", v, 8'hE0);
      bus_read(A_CTRL, v);
      chk("R12", "control kept", v, 8'h9E);
      chk("R12", "term_rdy_n after reset", term_rdy_n, 1'b1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_state();
      t_register_access();
      t_tx_back_to_back();
      t_cts_gating();
      t_rate_select();
      t_rx_irq();
      t_overrun();
      t_framing();
      t_irq_disabled();
      t_prog_reset();
      repeat (10) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule